// File: doc/BRIEF.md
# Clock-Buffer Configuration Target on a Two-Wire Bus

This block is the control side of a multi-output clock fan-out buffer. It sits on a two-wire serial bus as a target with the fixed 7-bit address 6Bh, so it answers the address byte D6h for writes and D7h for reads. A small file of six byte-wide configuration registers is reachable through it, and the register contents drive the block's parallel outputs directly: nine per-output enable bits, a custom-amplitude select and a three-bit amplitude code (000 means 300 mV, each step adds 100 mV, 111 means 1000 mV).

The bus lines are oversampled by the system clock. A synchroniser and edge detector turn them into SCL rise and fall strobes and START and STOP events. A state machine then walks each transfer. Its states are IDLE, ADDR (address byte shifting in), ADDR_ACK, CMD (command byte), CMD_ACK, WDATA (count or data byte from the master), WDATA_ACK, RDATA (byte shifting out), RACK (master acknowledge bit) and IGNORE (not addressed, or the master ended a read with a NACK).

The transitions are as follows. STOP goes to IDLE from any state, and START goes to ADDR from any state. ADDR goes to ADDR_ACK on an address match and to IGNORE otherwise. ADDR_ACK goes to RDATA for a read and to CMD for a write. CMD goes to CMD_ACK, and CMD_ACK goes to WDATA. WDATA goes to WDATA_ACK and back to WDATA. RDATA goes to RACK after eight bits. RACK goes back to RDATA on an ACK and to IGNORE on a NACK. The target only ever pulls SDA low.

Top module: `cfg_smbus_target`

## Requirements
- R1: After reset the six registers hold, at indices 0 to 5, the values 00h, 17h, F8h, 08h, 06h and D8h. The outputs therefore show all nine enables high, the custom select high and the amplitude code 101, and SDA is released.
- R2: The target acknowledges the address bytes D6h (write) and D7h (read). For any other address it leaves SDA released until the next START.
- R3: The command byte chooses the access kind and the start index. Bit 7 set means byte access and bit 7 clear means block access. Bits 6:0 give the first register index.
- R4: A byte write (START, D6h, command, one data byte, STOP) stores the data byte at the indexed register. Every byte is acknowledged.
- R5: A byte read (START, D6h, command, repeated START, D7h, one byte, NACK, STOP) returns the indexed register, MSB first.
- R6: In a block write the first byte after the command is a count. The next `count` data bytes go to ascending registers, and any further bytes are acknowledged but dropped. A STOP after any complete byte keeps the bytes already written.
- R7: In a block read the target first sends the content of register 4 as the count. It then sends registers from the start index upward for as long as the master acknowledges, and stops driving after a NACK.
- R8: Writes to indices above 5 are acknowledged but change nothing, and reads of such indices return 00h.
- R9: The enable outputs come from the registers as follows. Enable 0 is bit 4 of register 1, enable 1 is bit 2 and enable 2 is bit 1 of register 1, and enable 3 is bit 0 of register 1. Enables 4 to 8 come from bits 7 down to 3 of register 2. The enables change only after a register write.
- R10: The custom select is bit 7 of register 5 and the amplitude code is bits 6:4 of register 5. Both change only after a write to register 5.
- R11: The target never pulls SDA while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain) |
| out_en_o | output | 9 | Per-output clock enables |
| amp_custom_o | output | 1 | Custom amplitude selected |
| amp_code_o | output | 3 | Amplitude step, 300 mV plus 100 mV per step |

## Verification
The assertions assume that SDA changes only while SCL is low, except for the START and STOP conditions, and that each SCL phase lasts longer than the synchroniser delay plus one edge-detect cycle. Under those assumptions the register-write strobe and the address filter are the only causes of output changes and of bus drive. The bench holds every SCL phase for eight system clocks and changes SDA two clocks after each SCL fall, so no data change can look like START or STOP. It also checks each acknowledge bit as well as the outputs and the read-back bytes.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam int N_REG   = 6;
    localparam int CNT_REG = 4;
    localparam int AMP_REG = 5;
    localparam int N_OUT   = 9;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
        ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RACK, ST_IGNORE
    } bus_state_t;

    function automatic logic [7:0] reset_value(input int idx);
        case (idx)
            1:       return 8'h17;
            2:       return 8'hF8;
            3:       return 8'h08;
            4:       return 8'h06;
            5:       return 8'hD8;
            default: return 8'h00;
        endcase
    endfunction

    // register holding the enable of clock output k
    function automatic int oe_reg(input int k);
        return (k < 4) ? 1 : 2;
    endfunction

    // bit position of the enable of clock output k
    function automatic int oe_bit(input int k);
        case (k)
            0:       return 4;
            1:       return 2;
            2:       return 1;
            3:       return 0;
            default: return 11 - k;
        endcase
    endfunction
endpackage

// File: rtl/cfg_bus_sync.sv
module cfg_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_prev, sda_prev, scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_pkg::*;
#(
    parameter int NREG = N_REG,
    parameter int IW   = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [7:0]      wdata,
    input  logic [IW-1:0]   ridx,
    output logic [7:0]      rdata,
    output logic [N_OUT-1:0] out_en,
    output logic            amp_custom,
    output logic [2:0]      amp_code
);
    localparam int AW = $clog2(NREG);
    localparam logic [IW-1:0] LIMIT = IW'(NREG);

    logic [7:0] mem [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= reset_value(i);
        end else if (we && (widx < LIMIT)) begin
            mem[widx[AW-1:0]] <= wdata;
        end
    end

    assign rdata = (ridx < LIMIT) ? mem[ridx[AW-1:0]] : 8'h00;

    for (genvar k = 0; k < N_OUT; k++) begin : g_oe
        localparam int RI = oe_reg(k);
        localparam int BI = oe_bit(k);
        assign out_en[k] = mem[RI][BI];
    end

    assign amp_custom = mem[AMP_REG][7];
    assign amp_code   = mem[AMP_REG][6:4];
endmodule

// File: rtl/cfg_bus_fsm.sv
module cfg_bus_fsm
    import cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6B,
    parameter int         NREG     = N_REG,
    parameter int         CNT_IDX  = CNT_REG
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rdata,
    output logic [7:0] reg_ridx,
    output logic       reg_we,
    output logic [7:0] reg_widx,
    output logic [7:0] reg_wdata,
    output logic       sda_low,
    output bus_state_t state
);
    localparam logic [7:0] LIMIT = 8'(NREG);
    localparam logic [7:0] CNT_B = 8'(CNT_IDX);

    bus_state_t state_nx;
    logic [7:0] shreg, ptr, remain;
    logic [2:0] bitcnt;
    logic byte_done, rd_dir, cnt_pending, first_rd, master_ack;
    logic addr_hit, load_rd;

    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign reg_ridx = first_rd ? CNT_B : ptr;
    assign load_rd  = scl_fall && (((state == ST_ADDR_ACK) && rd_dir) ||
                                   ((state == ST_RACK) && master_ack));

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done)
                                  state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rd_dir ? ST_RDATA : ST_CMD;
                ST_CMD:       if (scl_fall && byte_done) state_nx = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (scl_fall && (bitcnt == 3'd7)) state_nx = ST_RACK;
                ST_RACK:      if (scl_fall) state_nx = master_ack ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg       <= '0;
            ptr         <= '0;
            remain      <= '0;
            bitcnt      <= '0;
            byte_done   <= 1'b0;
            rd_dir      <= 1'b0;
            cnt_pending <= 1'b0;
            first_rd    <= 1'b0;
            master_ack  <= 1'b0;
            reg_we      <= 1'b0;
            reg_widx    <= '0;
            reg_wdata   <= '0;
        end else begin
            reg_we <= 1'b0;
            if (start_det || stop_det) begin
                bitcnt    <= '0;
                byte_done <= 1'b0;
            end else if (load_rd) begin
                shreg  <= rdata;
                bitcnt <= '0;
                if (first_rd) first_rd <= 1'b0;
                else          ptr      <= ptr + 8'd1;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) byte_done <= 1'b1;
                        end else if (scl_fall && byte_done) begin
                            byte_done <= 1'b0;
                            if (state == ST_ADDR) begin
                                rd_dir <= shreg[0];
                            end else if (state == ST_CMD) begin
                                ptr         <= {1'b0, shreg[6:0]};
                                cnt_pending <= ~shreg[7];
                                first_rd    <= ~shreg[7];
                                remain      <= shreg[7] ? 8'd1 : 8'd0;
                            end else if (cnt_pending) begin
                                remain      <= shreg;
                                cnt_pending <= 1'b0;
                            end else if (remain != 8'd0) begin
                                if (ptr < LIMIT) begin
                                    reg_we    <= 1'b1;
                                    reg_widx  <= ptr;
                                    reg_wdata <= shreg;
                                end
                                ptr    <= ptr + 8'd1;
                                remain <= remain - 8'd1;
                            end
                        end
                    end
                    ST_RDATA: if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        bitcnt <= bitcnt + 3'd1;
                    end
                    ST_RACK: if (scl_rise) master_ack <= ~sda_s;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_low = 1'b1;
            ST_RDATA:                              sda_low = ~shreg[7];
            default:                               sda_low = 1'b0;
        endcase
    end
endmodule

// File: rtl/cfg_smbus_target.sv
module cfg_smbus_target
    import cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h6B,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    output logic [N_OUT-1:0] out_en_o,
    output logic             amp_custom_o,
    output logic [2:0]       amp_code_o
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic reg_we;
    logic [7:0] reg_widx, reg_wdata, reg_ridx, rdata;
    bus_state_t bus_state;

    cfg_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_i), .sda_in(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cfg_bus_fsm #(.DEV_ADDR(DEV_ADDR), .NREG(N_REG), .CNT_IDX(CNT_REG)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
        .rdata(rdata), .reg_ridx(reg_ridx), .reg_we(reg_we),
        .reg_widx(reg_widx), .reg_wdata(reg_wdata), .sda_low(sda_pull_o),
        .state(bus_state)
    );

    cfg_regfile #(.NREG(N_REG), .IW(8)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .widx(reg_widx),
        .wdata(reg_wdata), .ridx(reg_ridx), .rdata(rdata),
        .out_en(out_en_o), .amp_custom(amp_custom_o), .amp_code(amp_code_o)
    );
endmodule

// File: rtl/cfg_smbus_target_chk.sv
module cfg_smbus_target_chk
    import cfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             sda_pull,
    input bus_state_t       bus_state,
    input logic             reg_we,
    input logic [7:0]       reg_widx,
    input logic [N_OUT-1:0] out_en,
    input logic             amp_custom,
    input logic [2:0]       amp_code
);
    // R1
    reset_vals_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (out_en == 9'h1FF) && amp_custom && (amp_code == 3'd5));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_IDLE) |-> !sda_pull);

    // R2
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_state == ST_IGNORE) |-> !sda_pull);

    // R8
    write_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> (reg_widx < 8'(N_REG)));

    // R9
    oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_en) |-> $past(reg_we));

    // R10
    amp_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({amp_custom, amp_code}) |-> ($past(reg_we) && ($past(reg_widx) == 8'(AMP_REG))));
endmodule

bind cfg_smbus_target cfg_smbus_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .bus_state(bus_state),
    .reg_we(reg_we), .reg_widx(reg_widx), .out_en(out_en_o),
    .amp_custom(amp_custom_o), .amp_code(amp_code_o)
);

// File: tb/cfg_smbus_target_test.sv
module cfg_smbus_target_test;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, scl, sda_m;
    logic sda_pull;
    logic [8:0] out_en;
    logic amp_custom;
    logic [2:0] amp_code;
    logic sda_line;
    assign sda_line = sda_m & ~sda_pull;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    cfg_smbus_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .out_en_o(out_en),
        .amp_custom_o(amp_custom), .amp_code_o(amp_code)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_rstart();
        tick(2); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(2); sda_m = 1'b0; tick(Q); scl = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(2); sda_m = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
        end
        tick(2); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q/2);
        ack = ~sda_line;
        tick(Q/2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            tick(2); sda_m = 1'b1; tick(Q); scl = 1'b1; tick(Q/2);
            b = {b[6:0], sda_line};
            tick(Q/2); scl = 1'b0;
        end
        tick(2); sda_m = give_ack ? 1'b0 : 1'b1; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0;
    endtask

    // write frame: address D6h, command, then n bytes from wbuf, all must be acked
    task automatic wr_frame(input logic [7:0] cmd, input int n, input string req);
        logic a;
        bus_start();
        send_byte(8'hD6, a); chk({req, " addr ack"}, a, 1'b1);
        send_byte(cmd, a);   chk({req, " cmd ack"}, a, 1'b1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); chk({req, " data ack"}, a, 1'b1);
        end
        bus_stop();
        tick(4);
    endtask

    // read frame: command, repeated start, D7h, n bytes into rbuf, last NACKed
    task automatic rd_frame(input logic [7:0] cmd, input int n, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD6, a); chk({req, " addr ack"}, a, 1'b1);
        send_byte(cmd, a);   chk({req, " cmd ack"}, a, 1'b1);
        bus_rstart();
        send_byte(8'hD7, a); chk({req, " read addr ack"}, a, 1'b1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            rbuf[i] = b;
        end
        bus_stop();
        tick(4);
        chk({req, " released after read"}, sda_pull, 1'b0);
    endtask

    task automatic t_reset();
        chk("R1 enables", out_en, 9'h1FF);
        chk("R1 amp select", amp_custom, 1'b1);
        chk("R1 amp code", amp_code, 3'd5);
        chk("R11 idle release", sda_pull, 1'b0);
        rd_frame(8'h83, 1, "R5");
        chk("R1 reg3 reset", rbuf[0], 8'h08);
        rd_frame(8'h80, 1, "R5");
        chk("R1 reg0 reset", rbuf[0], 8'h00);
    endtask

    task automatic t_byte_write();
        // R4 R9: register 1 bits 4,2,1,0 -> enables 0..3
        wbuf[0] = 8'h00; wr_frame(8'h81, 1, "R4");
        chk("R9 reg1 cleared", out_en, 9'h1F0);
        wbuf[0] = 8'h10; wr_frame(8'h81, 1, "R4");
        chk("R9 enable0 from bit4", out_en, 9'h1F1);
        wbuf[0] = 8'h04; wr_frame(8'h81, 1, "R4");
        chk("R9 enable1 from bit2", out_en, 9'h1F2);
        wbuf[0] = 8'h02; wr_frame(8'h81, 1, "R4");
        chk("R9 enable2 from bit1", out_en, 9'h1F4);
        wbuf[0] = 8'h01; wr_frame(8'h81, 1, "R4");
        chk("R9 enable3 from bit0", out_en, 9'h1F8);
    endtask

    task automatic t_amp();
        wbuf[0] = 8'hE0; wr_frame(8'h85, 1, "R10");
        chk("R10 select", amp_custom, 1'b1);
        chk("R10 code 110", amp_code, 3'd6);
        wbuf[0] = 8'h30; wr_frame(8'h85, 1, "R10");
        chk("R10 select off", amp_custom, 1'b0);
        chk("R10 code 011", amp_code, 3'd3);
        chk("R10 enables untouched", out_en, 9'h1F8);
    endtask

    task automatic t_byte_read();
        rd_frame(8'h81, 1, "R5");
        chk("R5 read reg1", rbuf[0], 8'h01);
        rd_frame(8'h82, 1, "R5");
        chk("R5 R3 byte mode read reg2", rbuf[0], 8'hF8);
    endtask

    task automatic t_block_write();
        // R6: count 2 starting at index 2 (block mode, command bit7 clear, R3)
        wbuf[0] = 8'h02; wbuf[1] = 8'h08; wbuf[2] = 8'h46;
        wr_frame(8'h02, 3, "R6");
        chk("R6 R9 reg2 bit3 -> enable8", out_en, 9'h108);
        rd_frame(8'h83, 1, "R6");
        chk("R6 reg3 written", rbuf[0], 8'h46);
        // count 1, second data byte is dropped (would have hit reg2)
        wbuf[0] = 8'h01; wbuf[1] = 8'h10; wbuf[2] = 8'h00;
        wr_frame(8'h01, 3, "R6");
        chk("R6 extra byte dropped", out_en, 9'h101);
    endtask

    task automatic t_block_read();
        rd_frame(8'h00, 8, "R7");
        chk("R7 count from reg4", rbuf[0], 8'h06);
        chk("R7 reg0", rbuf[1], 8'h00);
        chk("R7 reg1", rbuf[2], 8'h10);
        chk("R7 reg2", rbuf[3], 8'h08);
        chk("R7 reg3", rbuf[4], 8'h46);
        chk("R7 reg4", rbuf[5], 8'h06);
        chk("R7 reg5", rbuf[6], 8'h30);
        chk("R8 index6 reads zero", rbuf[7], 8'h00);
        rd_frame(8'h03, 3, "R7");
        chk("R7 count again", rbuf[0], 8'h06);
        chk("R7 start index3", rbuf[1], 8'h46);
        chk("R7 next index4", rbuf[2], 8'h06);
    endtask

    task automatic t_range();
        wbuf[0] = 8'hAA; wr_frame(8'h87, 1, "R8");
        chk("R8 enables unchanged", out_en, 9'h101);
        chk("R8 amp unchanged", amp_code, 3'd3);
        rd_frame(8'h87, 1, "R8");
        chk("R8 index7 reads zero", rbuf[0], 8'h00);
        // block write running past index 5
        wbuf[0] = 8'h03; wbuf[1] = 8'h70; wbuf[2] = 8'h11; wbuf[3] = 8'h22;
        wr_frame(8'h05, 4, "R8");
        chk("R8 R10 reg5 written", amp_code, 3'd7);
        chk("R8 enables kept", out_en, 9'h101);
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'hA6, a); chk("R2 foreign address nacked", a, 1'b0);
        send_byte(8'h81, a); chk("R2 stays silent", a, 1'b0);
        send_byte(8'hFF, a); chk("R2 stays silent data", a, 1'b0);
        bus_stop();
        tick(4);
        chk("R2 no write", out_en, 9'h101);
        chk("R11 idle after stop", sda_pull, 1'b0);
    endtask

    task automatic t_partial();
        logic a;
        bus_start();
        send_byte(8'hD6, a); chk("R6 addr ack", a, 1'b1);
        send_byte(8'h01, a); chk("R6 cmd ack", a, 1'b1);
        send_byte(8'h02, a); chk("R6 count ack", a, 1'b1);
        send_byte(8'h17, a); chk("R6 data ack", a, 1'b1);
        bus_stop();
        tick(4);
        chk("R6 stop keeps first byte", out_en, 9'h10F);
        rd_frame(8'h82, 1, "R6");
        chk("R6 reg2 not reached", rbuf[0], 8'h08);
    endtask

    initial begin
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1;
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_byte_write();
        t_amp();
        t_byte_read();
        t_block_write();
        t_block_read();
        t_range();
        t_bad_addr();
        t_partial();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule